// File: doc/BRIEF.md
# Ring Descriptor Frame DMA

This block moves Ethernet frames between a byte-stream interface and a buffer memory. Both sides are driven by rings of descriptors held in an internal descriptor memory. Software fills descriptors and buffers through a simple word port. It hands a descriptor to the engine by setting its ownership bit, then sets a request bit to start the transmit or receive side.

On transmit, the engine fetches the descriptor, streams the frame bytes out with a valid/ready handshake, and then gives the descriptor back. On receive, it fills the buffer from the input stream and writes back the stored byte count and a packed error summary. It then gives the descriptor back and raises a sticky frame-received interrupt. When either side reaches a descriptor it does not own, it stops and clears its own request bit. A descriptor marked as last sends its ring back to the first entry.

Top module: `ring_frame_dma`

## Requirements
- R1: After reset, both request bits read 0, `irq` is low, `tx_valid` is low and `rx_ready` is low.
- R2: For an owned transmit descriptor with length L in bits 31:16 of word 1 (1 ≤ L ≤ MAX_TX_LEN), the engine streams the L buffer bytes that start at the byte address in word 2, in order. `tx_last` is set on the final byte only.
- R3: When a transmit frame is done, the engine writes word 0 back with bit 31 (ownership) cleared. All other bits of word 0 are unchanged. The engine then moves to the next descriptor.
- R4: Bit 30 of word 0 (last) sends a ring back to descriptor 0 after that descriptor is processed. Descriptors that follow it are never fetched. A ring also wraps after its final entry.
- R5: When a ring's request bit is set and the current descriptor has bit 31 clear, that request bit clears, no data moves, and the descriptor index stays where it is. Nothing more happens until software sets the bit again.
- R6: For an owned receive descriptor, the engine stores the incoming bytes from the buffer address onward. It writes word 1 as {buffer length in bits 31:16 unchanged, stored count in bits 15:0}. Word 0 is then written with bit 31 cleared.
- R7: Bytes beyond the buffer length in bits 31:16 of word 1 are dropped and leave the buffer memory unchanged. The frame is then flagged with overflow status (bit 25).
- R8: Receive word 0 is written back as follows. Bit 30 is kept. `rx_cause` bits 0..6 (CRC, PHY error, too short, too long, residual bits, multicast, overflow), taken with the last byte, map to status bits 16, 17, 18, 19, 20, 22 and 25. Bit 27 is set exactly when any status bit is set. All other bits are 0.
- R9: Each completed receive frame sets a sticky status bit (control word 1, bit 0). Writing 1 to that bit clears it. `irq` equals that status ANDed with the enable bit (control word 2, bit 0).
- R10: Writing 1 to control word 3, bit 0 resets the block in software. On the next cycle both sides are idle, both request bits are 0, and both rings restart at descriptor 0.
- R11: A transmit descriptor with length 0 or a length above MAX_TX_LEN sends no bytes, but it is still handed back as in R3.
- R12: While `tx_valid` is high and `tx_ready` is low, `tx_valid`, `tx_data` and `tx_last` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sw_we | input | 1 | Software write strobe |
| sw_sel | input | 2 | Space select: 0 = descriptor words, 1 = buffer bytes, 2 = control words |
| sw_addr | input | SW_AW | Word index (descriptor), byte index (buffer) or control word number |
| sw_wdata | input | 32 | Software write data |
| sw_rdata | output | 32 | Combinational read data for the selected address |
| tx_valid | output | 1 | Transmit byte valid |
| tx_ready | input | 1 | Transmit sink accepts a byte |
| tx_data | output | 8 | Transmit byte |
| tx_last | output | 1 | Final byte of the frame |
| rx_valid | input | 1 | Receive byte valid |
| rx_ready | output | 1 | Engine is accepting receive bytes |
| rx_data | input | 8 | Receive byte |
| rx_last | input | 1 | Final byte of the receive frame |
| rx_cause | input | 7 | Error causes of the frame, taken with the last byte |
| irq | output | 1 | Frame-received interrupt |

## Verification
A wrong ring index shows up at `tx_data` in the next frame: its bytes come from the wrong buffer region, or nothing is sent because an unowned entry was fetched. The request bit also reads back 0 within a few cycles. A wrong receive count or wrong status packing shows in the written-back descriptor words as soon as the ownership bit is released, about three cycles after the last byte. A bad interrupt state shows on `irq` the cycle after the write-back of the status word. A lost or duplicated transmit byte shifts every byte that follows, so a per-byte compare catches it at once.

// File: rtl/fdma_pkg.sv
package fdma_pkg;

    localparam logic [1:0] SEL_DESC = 2'd0;
    localparam logic [1:0] SEL_BUF  = 2'd1;
    localparam logic [1:0] SEL_CTRL = 2'd2;

    localparam int CW_REQ = 0;
    localparam int CW_IRQ = 1;
    localparam int CW_EN  = 2;
    localparam int CW_RST = 3;

    localparam int OWN_BIT  = 31;
    localparam int LAST_BIT = 30;

    typedef enum logic [2:0] {
        TX_IDLE, TX_LEN, TX_ADR, TX_SEND, TX_DONE
    } tx_state_e;

    typedef enum logic [2:0] {
        RX_IDLE, RX_LEN, RX_ADR, RX_RECV, RX_WLEN, RX_WSTAT
    } rx_state_e;

    // cause inputs -> 10-bit status field (field bit n is word-0 bit 16+n)
    function automatic logic [9:0] cause_to_stat(input logic [6:0] c);
        logic [9:0] s;
        s    = '0;
        s[0] = c[0];
        s[1] = c[1];
        s[2] = c[2];
        s[3] = c[3];
        s[4] = c[4];
        s[6] = c[5];
        s[9] = c[6];
        return s;
    endfunction

endpackage

// File: rtl/fdma_ram.sv
module fdma_ram #(
    parameter int W     = 32,
    parameter int DEPTH = 16,
    parameter int NWR   = 2,
    parameter int NRD   = 2,
    parameter int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic [NWR-1:0] we,
    input  logic [AW-1:0] waddr [NWR],
    input  logic [W-1:0]  wdata [NWR],
    input  logic [AW-1:0] raddr [NRD],
    output logic [W-1:0]  rdata [NRD]
);

    logic [W-1:0] mem [DEPTH];

    // higher-numbered write port wins on a same-address collision
    always_ff @(posedge clk) begin
        for (int p = 0; p < NWR; p++) begin
            if (we[p]) mem[waddr[p]] <= wdata[p];
        end
    end

    for (genvar r = 0; r < NRD; r++) begin : g_rd
        assign rdata[r] = mem[raddr[r]];
    end

endmodule

// File: rtl/ring_frame_dma.sv
module ring_frame_dma
    import fdma_pkg::*;
#(
    parameter int TX_DESC    = 2,
    parameter int RX_DESC    = 2,
    parameter int BUF_BYTES  = 256,
    parameter int MAX_TX_LEN = 1514,
    parameter int SW_AW      = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sw_we,
    input  logic [1:0]       sw_sel,
    input  logic [SW_AW-1:0] sw_addr,
    input  logic [31:0]      sw_wdata,
    output logic [31:0]      sw_rdata,
    output logic             tx_valid,
    input  logic             tx_ready,
    output logic [7:0]       tx_data,
    output logic             tx_last,
    input  logic             rx_valid,
    output logic             rx_ready,
    input  logic [7:0]       rx_data,
    input  logic             rx_last,
    input  logic [6:0]       rx_cause,
    output logic             irq
);

    localparam int DESC_WORDS = (TX_DESC + RX_DESC) * 4;
    localparam int DAW = $clog2(DESC_WORDS);
    localparam int BAW = $clog2(BUF_BYTES);
    localparam int TIW = (TX_DESC > 1) ? $clog2(TX_DESC) : 1;
    localparam int RIW = (RX_DESC > 1) ? $clog2(RX_DESC) : 1;

    typedef struct packed {
        tx_state_e      tx_st;
        logic [TIW-1:0] tx_idx;
        logic [31:0]    tx_w0;
        logic [15:0]    tx_len;
        logic [BAW-1:0] tx_ptr;
        logic [15:0]    tx_cnt;
        logic           tx_req;
        rx_state_e      rx_st;
        logic [RIW-1:0] rx_idx;
        logic           rx_lastd;
        logic [15:0]    rx_blen;
        logic [BAW-1:0] rx_ptr;
        logic [15:0]    rx_cnt;
        logic [9:0]     rx_stat;
        logic           rx_req;
        logic           irq_st;
        logic           irq_en;
    } state_t;

    state_t q, d;

    logic [2:0]     dwe;
    logic [DAW-1:0] dwa [3];
    logic [31:0]    dwd [3];
    logic [DAW-1:0] dra [3];
    logic [31:0]    drd [3];
    logic [1:0]     bwe;
    logic [BAW-1:0] bwa [2];
    logic [7:0]     bwd [2];
    logic [BAW-1:0] bra [2];
    logic [7:0]     brd [2];

    fdma_ram #(.W(32), .DEPTH(DESC_WORDS), .NWR(3), .NRD(3), .AW(DAW)) desc_ram_i (
        .clk(clk), .we(dwe), .waddr(dwa), .wdata(dwd), .raddr(dra), .rdata(drd)
    );

    fdma_ram #(.W(8), .DEPTH(BUF_BYTES), .NWR(2), .NRD(2), .AW(BAW)) buf_ram_i (
        .clk(clk), .we(bwe), .waddr(bwa), .wdata(bwd), .raddr(bra), .rdata(brd)
    );

    logic ctrl_wr, srst, irq_clr, req_wr;
    logic [1:0] tx_word, rx_word;
    logic [DAW-1:0] tx_da, rx_da;

    assign ctrl_wr = sw_we && (sw_sel == SEL_CTRL);
    assign srst    = ctrl_wr && (sw_addr == SW_AW'(CW_RST)) && sw_wdata[0];
    assign irq_clr = ctrl_wr && (sw_addr == SW_AW'(CW_IRQ)) && sw_wdata[0];
    assign req_wr  = ctrl_wr && (sw_addr == SW_AW'(CW_REQ));

    assign tx_word = (q.tx_st == TX_LEN) ? 2'd1 : (q.tx_st == TX_ADR) ? 2'd2 : 2'd0;
    assign rx_word = (q.rx_st == RX_LEN || q.rx_st == RX_WLEN) ? 2'd1 :
                     (q.rx_st == RX_ADR) ? 2'd2 : 2'd0;
    assign tx_da = DAW'(int'(q.tx_idx) * 4 + int'(tx_word));
    assign rx_da = DAW'((TX_DESC + int'(q.rx_idx)) * 4 + int'(rx_word));

    always_comb begin
        d = q;
        // descriptor memory: port 0 software, 1 transmit, 2 receive
        dwe    = '0;
        dwe[0] = sw_we && (sw_sel == SEL_DESC);
        dwa[0] = sw_addr[DAW-1:0];
        dwd[0] = sw_wdata;
        dra[0] = sw_addr[DAW-1:0];
        dwa[1] = tx_da;
        dwd[1] = q.tx_w0 & ~(32'h1 << OWN_BIT);
        dra[1] = tx_da;
        dwa[2] = rx_da;
        dra[2] = rx_da;
        dwd[2] = (q.rx_st == RX_WLEN) ? {q.rx_blen, q.rx_cnt}
               : {1'b0, q.rx_lastd, 2'b00, |q.rx_stat, 1'b0, q.rx_stat, 16'h0};
        // buffer memory: port 0 software, 1 receive writes / transmit reads
        bwe    = '0;
        bwe[0] = sw_we && (sw_sel == SEL_BUF);
        bwa[0] = sw_addr[BAW-1:0];
        bwd[0] = sw_wdata[7:0];
        bra[0] = sw_addr[BAW-1:0];
        bra[1] = q.tx_ptr + q.tx_cnt[BAW-1:0];
        bwa[1] = q.rx_ptr + q.rx_cnt[BAW-1:0];
        bwd[1] = rx_data;

        if (irq_clr) d.irq_st = 1'b0;
        if (ctrl_wr && (sw_addr == SW_AW'(CW_EN))) d.irq_en = sw_wdata[0];

        case (q.tx_st)
            TX_IDLE: if (q.tx_req) begin
                if (!drd[1][OWN_BIT]) d.tx_req = 1'b0;
                else begin
                    d.tx_w0 = drd[1];
                    d.tx_st = TX_LEN;
                end
            end
            TX_LEN: begin
                d.tx_len = drd[1][31:16];
                d.tx_st  = TX_ADR;
            end
            TX_ADR: begin
                d.tx_ptr = drd[1][BAW-1:0];
                d.tx_cnt = '0;
                d.tx_st  = (q.tx_len == 16'd0 || q.tx_len > 16'(MAX_TX_LEN)) ? TX_DONE : TX_SEND;
            end
            TX_SEND: if (tx_ready) begin
                d.tx_cnt = q.tx_cnt + 16'd1;
                if (tx_last) d.tx_st = TX_DONE;
            end
            TX_DONE: begin
                dwe[1]   = 1'b1;
                d.tx_idx = (q.tx_w0[LAST_BIT] || int'(q.tx_idx) == TX_DESC - 1)
                         ? '0 : q.tx_idx + TIW'(1);
                d.tx_st  = TX_IDLE;
            end
            default: d.tx_st = TX_IDLE;
        endcase

        case (q.rx_st)
            RX_IDLE: if (q.rx_req) begin
                if (!drd[2][OWN_BIT]) d.rx_req = 1'b0;
                else begin
                    d.rx_lastd = drd[2][LAST_BIT];
                    d.rx_st    = RX_LEN;
                end
            end
            RX_LEN: begin
                d.rx_blen = drd[2][31:16];
                d.rx_st   = RX_ADR;
            end
            RX_ADR: begin
                d.rx_ptr  = drd[2][BAW-1:0];
                d.rx_cnt  = '0;
                d.rx_stat = '0;
                d.rx_st   = RX_RECV;
            end
            RX_RECV: if (rx_valid) begin
                if (q.rx_cnt < q.rx_blen) begin
                    bwe[1]   = 1'b1;
                    d.rx_cnt = q.rx_cnt + 16'd1;
                end else begin
                    d.rx_stat[9] = 1'b1;
                end
                if (rx_last) begin
                    d.rx_stat = d.rx_stat | cause_to_stat(rx_cause);
                    d.rx_st   = RX_WLEN;
                end
            end
            RX_WLEN: begin
                dwe[2]  = 1'b1;
                d.rx_st = RX_WSTAT;
            end
            RX_WSTAT: begin
                dwe[2]   = 1'b1;
                d.irq_st = 1'b1;
                d.rx_idx = (q.rx_lastd || int'(q.rx_idx) == RX_DESC - 1)
                         ? '0 : q.rx_idx + RIW'(1);
                d.rx_st  = RX_IDLE;
            end
            default: d.rx_st = RX_IDLE;
        endcase

        if (req_wr && sw_wdata[0]) d.tx_req = 1'b1;
        if (req_wr && sw_wdata[1]) d.rx_req = 1'b1;

        if (srst) begin
            d.tx_st  = TX_IDLE;
            d.tx_idx = '0;
            d.tx_req = 1'b0;
            d.rx_st  = RX_IDLE;
            d.rx_idx = '0;
            d.rx_req = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign tx_valid = (q.tx_st == TX_SEND);
    assign tx_data  = brd[1];
    assign tx_last  = (q.tx_cnt == q.tx_len - 16'd1);
    assign rx_ready = (q.rx_st == RX_RECV);
    assign irq      = q.irq_st & q.irq_en;

    always_comb begin
        sw_rdata = '0;
        case (sw_sel)
            SEL_DESC: sw_rdata = drd[0];
            SEL_BUF:  sw_rdata = {24'h0, brd[0]};
            SEL_CTRL: begin
                if (sw_addr == SW_AW'(CW_REQ)) sw_rdata = {30'h0, q.rx_req, q.tx_req};
                if (sw_addr == SW_AW'(CW_IRQ)) sw_rdata = {31'h0, q.irq_st};
                if (sw_addr == SW_AW'(CW_EN))  sw_rdata = {31'h0, q.irq_en};
            end
            default: sw_rdata = '0;
        endcase
    end

    logic unused_rx_word;
    assign unused_rx_word = ^drd[2];

    AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid && !tx_ready && !srst |=> tx_valid && $stable(tx_data) && $stable(tx_last)); // R12
    AST_TX_LAST_END: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid && tx_ready && tx_last |=> !tx_valid); // R2
    AST_RX_LAST_END: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid && rx_ready && rx_last |=> !rx_ready); // R6
    AST_SRST_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        srst |=> !tx_valid && !rx_ready && (q.tx_idx == '0) && (q.rx_idx == '0)); // R10
    AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        q.irq_st && !irq_clr |=> q.irq_st); // R9
    AST_TX_SUSPEND: assert property (@(posedge clk) disable iff (!rst_n)
        (q.tx_st == TX_IDLE) && q.tx_req && !drd[1][OWN_BIT] && !(req_wr && sw_wdata[0]) && !srst
        |=> !q.tx_req && $stable(q.tx_idx)); // R5

endmodule

// File: tb/ring_frame_dma_tb_top.sv
module ring_frame_dma_tb_top;
    import fdma_pkg::*;

    localparam int NTX = 3;
    localparam int NRX = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sw_we = 1'b0;
    logic [1:0] sw_sel = 2'd0;
    logic [8:0] sw_addr = '0;
    logic [31:0] sw_wdata = '0;
    logic [31:0] sw_rdata;
    logic tx_valid, tx_last, rx_ready, irq;
    logic tx_ready = 1'b0;
    logic [7:0] tx_data;
    logic rx_valid = 1'b0, rx_last = 1'b0;
    logic [7:0] rx_data = '0;
    logic [6:0] rx_cause = '0;

    int checks = 0, fails = 0;
    byte unsigned txs [0:4095];
    bit txl [0:4095];
    int txn = 0;
    bit prev_stall = 0;
    logic [7:0] prev_data;
    logic prev_last;
    byte unsigned exp_b [0:127];
    byte unsigned rxb [0:63];

    always #10 clk = ~clk;

    ring_frame_dma #(.TX_DESC(NTX), .RX_DESC(NRX), .BUF_BYTES(512),
                     .MAX_TX_LEN(1514), .SW_AW(9)) dut_i (
        .clk(clk), .rst_n(rst_n), .sw_we(sw_we), .sw_sel(sw_sel), .sw_addr(sw_addr),
        .sw_wdata(sw_wdata), .sw_rdata(sw_rdata), .tx_valid(tx_valid), .tx_ready(tx_ready),
        .tx_data(tx_data), .tx_last(tx_last), .rx_valid(rx_valid), .rx_ready(rx_ready),
        .rx_data(rx_data), .rx_last(rx_last), .rx_cause(rx_cause), .irq(irq));

    // transmit sink: random back-pressure, capture, hold check
    always @(negedge clk) begin
        if (rst_n) begin
            if (prev_stall) begin
                checks++;
                if (!tx_valid || tx_data !== prev_data || tx_last !== prev_last) begin
                    fails++;
                    $display("FAIL R12 stall hold actual=%b/%h/%b expected=1/%h/%b",
                             tx_valid, tx_data, tx_last, prev_data, prev_last);
                end
            end
            tx_ready = ($urandom % 4) != 0;
            if (tx_valid && tx_ready) begin
                txs[txn] = tx_data;
                txl[txn] = tx_last;
                txn++;
            end
            prev_stall = tx_valid && !tx_ready;
            prev_data  = tx_data;
            prev_last  = tx_last;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic sw_wr(input logic [1:0] s, input int a, input logic [31:0] v);
        @(negedge clk);
        sw_we = 1'b1; sw_sel = s; sw_addr = 9'(a); sw_wdata = v;
        @(negedge clk);
        sw_we = 1'b0;
    endtask

    task automatic sw_rd(input logic [1:0] s, input int a, output logic [31:0] v);
        @(negedge clk);
        sw_sel = s; sw_addr = 9'(a);
        #1 v = sw_rdata;
    endtask

    function automatic int txd(input int i, input int w); return i * 4 + w; endfunction
    function automatic int rxd(input int i, input int w); return (NTX + i) * 4 + w; endfunction
    function automatic int txb(input int i); return i * 64; endfunction
    function automatic int rxbase(input int i); return 192 + i * 64; endfunction

    function automatic logic [31:0] stat_word(input logic [6:0] c, input bit ovf, input bit lst);
        logic [31:0] s;
        s = 32'h0;
        if (c[0]) s[16] = 1'b1;
        if (c[1]) s[17] = 1'b1;
        if (c[2]) s[18] = 1'b1;
        if (c[3]) s[19] = 1'b1;
        if (c[4]) s[20] = 1'b1;
        if (c[5]) s[22] = 1'b1;
        if (c[6] || ovf) s[25] = 1'b1;
        if (s != 0) s[27] = 1'b1;
        if (lst) s[30] = 1'b1;
        return s;
    endfunction

    task automatic wait_req_clear(input int bitn, input string tag);
        logic [31:0] v;
        for (int k = 0; k < 2000; k++) begin
            sw_rd(SEL_CTRL, CW_REQ, v);
            if (!v[bitn]) return;
        end
        chk(tag, v[bitn], 32'h0);
    endtask

    task automatic wait_rx_free(input int i, input string tag);
        logic [31:0] v;
        for (int k = 0; k < 500; k++) begin
            sw_rd(SEL_DESC, rxd(i, 0), v);
            if (!v[31]) return;
        end
        chk(tag, v[31], 32'h0);
    endtask

    task automatic arm_tx(input int i, input int len, input bit lst);
        sw_wr(SEL_DESC, txd(i, 1), 32'(len) << 16);
        sw_wr(SEL_DESC, txd(i, 2), 32'(txb(i)));
        sw_wr(SEL_DESC, txd(i, 0), 32'hB000_0000 | (lst ? 32'h4000_0000 : 32'h0));
    endtask

    task automatic arm_rx(input int i, input int blen, input bit lst);
        sw_wr(SEL_DESC, rxd(i, 1), 32'(blen) << 16);
        sw_wr(SEL_DESC, rxd(i, 2), 32'(rxbase(i)));
        sw_wr(SEL_DESC, rxd(i, 0), 32'h8000_0000 | (lst ? 32'h4000_0000 : 32'h0));
    endtask

    task automatic fill_tx(input int i, input int len, input int off);
        for (int k = 0; k < len; k++) begin
            byte unsigned b;
            b = 8'($urandom);
            exp_b[off + k] = b;
            sw_wr(SEL_BUF, txb(i) + k, {24'h0, b});
        end
    endtask

    task automatic send_rx(input int n, input logic [6:0] cause);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            while (!rx_ready) @(negedge clk);
            rx_valid = 1'b1; rx_data = rxb[k]; rx_last = (k == n - 1);
            rx_cause = (k == n - 1) ? cause : 7'h0;
        end
        @(negedge clk);
        rx_valid = 1'b0; rx_last = 1'b0; rx_cause = 7'h0;
    endtask

    task automatic check_stream(input int base, input int total, input int l0, input string tag);
        int bad;
        int lastbad;
        bad = 0;
        lastbad = 0;
        chk({tag, " byte count"}, 32'(txn - base), 32'(total));
        for (int k = 0; k < total; k++) begin
            if (txs[base + k] != exp_b[k]) bad++;
            if (txl[base + k] != ((k == l0 - 1) || (k == total - 1))) lastbad++;
        end
        chk({tag, " data mismatches"}, 32'(bad), 32'h0);
        chk({tag, " last flag mismatches"}, 32'(lastbad), 32'h0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] v;
        int base, l0, l1;
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 irq", {31'h0, irq}, 32'h0);
        chk("R1 tx_valid", {31'h0, tx_valid}, 32'h0);
        chk("R1 rx_ready", {31'h0, rx_ready}, 32'h0);
        sw_rd(SEL_CTRL, CW_REQ, v);
        chk("R1 request bits", v, 32'h0);
        rst_n = 1'b1;

        // descriptor 2 is owned but must never be fetched (R4)
        sw_wr(SEL_DESC, txd(2, 1), 32'h0005_0000);
        sw_wr(SEL_DESC, txd(2, 2), 32'(txb(2)));
        sw_wr(SEL_DESC, txd(2, 0), 32'hB000_0000);

        // R2/R3/R4: random two-frame rounds, descriptor 1 is last
        for (int r = 0; r < 3; r++) begin
            l0 = 1 + ($urandom % 64);
            l1 = 1 + ($urandom % 64);
            if (r == 0) begin l0 = 1; l1 = 64; end
            fill_tx(0, l0, 0);
            fill_tx(1, l1, l0);
            arm_tx(0, l0, 1'b0);
            arm_tx(1, l1, 1'b1);
            base = txn;
            sw_wr(SEL_CTRL, CW_REQ, 32'h1);
            wait_req_clear(0, "R5 tx request clear after ring");
            repeat (4) @(negedge clk);
            check_stream(base, l0 + l1, l0, "R2 round");
            sw_rd(SEL_DESC, txd(0, 0), v);
            chk("R3 desc0 word0 handed back", v, 32'h3000_0000);
            sw_rd(SEL_DESC, txd(1, 0), v);
            chk("R3 desc1 word0 handed back keeps last", v, 32'h7000_0000);
            sw_rd(SEL_DESC, txd(2, 0), v);
            chk("R4 desc2 never fetched after last wrap", v, 32'hB000_0000);
        end

        // R5: request with nothing owned -> clears, no data; then resume
        base = txn;
        sw_wr(SEL_CTRL, CW_REQ, 32'h1);
        wait_req_clear(0, "R5 unowned clears request");
        repeat (4) @(negedge clk);
        chk("R5 no bytes while suspended", 32'(txn - base), 32'h0);
        l0 = 1 + ($urandom % 64);
        fill_tx(0, l0, 0);
        arm_tx(0, l0, 1'b0);
        base = txn;
        sw_wr(SEL_CTRL, CW_REQ, 32'h1);
        wait_req_clear(0, "R5 resume");
        repeat (4) @(negedge clk);
        check_stream(base, l0, l0, "R5 resume");

        // R11: zero length at desc1 (last), oversize at desc0
        sw_wr(SEL_DESC, txd(1, 1), 32'h0);
        sw_wr(SEL_DESC, txd(1, 0), 32'hF000_0000);
        sw_wr(SEL_DESC, txd(0, 1), 32'(1515) << 16);
        sw_wr(SEL_DESC, txd(0, 0), 32'hB000_0000);
        base = txn;
        sw_wr(SEL_CTRL, CW_REQ, 32'h1);
        wait_req_clear(0, "R11 request clear");
        repeat (4) @(negedge clk);
        chk("R11 no bytes for length 0 / oversize", 32'(txn - base), 32'h0);
        sw_rd(SEL_DESC, txd(1, 0), v);
        chk("R11 zero-length desc handed back", v, 32'h7000_0000);
        sw_rd(SEL_DESC, txd(0, 0), v);
        chk("R11 oversize desc handed back", v, 32'h3000_0000);

        // R6/R9: receive into desc0, interrupt enabled
        sw_wr(SEL_CTRL, CW_EN, 32'h1);
        arm_rx(0, 64, 1'b0);
        arm_rx(1, 8, 1'b1);
        sw_wr(SEL_BUF, rxbase(1) + 8, 32'hA5);
        l0 = 1 + ($urandom % 64);
        for (int k = 0; k < 64; k++) rxb[k] = 8'($urandom);
        sw_wr(SEL_CTRL, CW_REQ, 32'h2);
        send_rx(l0, 7'h0);
        wait_rx_free(0, "R6 rx desc0 handed back");
        repeat (2) @(negedge clk);
        sw_rd(SEL_DESC, rxd(0, 1), v);
        chk("R6 word1 length and count", v, (32'd64 << 16) | 32'(l0));
        sw_rd(SEL_DESC, rxd(0, 0), v);
        chk("R6 R8 clean word0", v, stat_word(7'h0, 1'b0, 1'b0));
        base = 0;
        for (int k = 0; k < l0; k++) begin
            sw_rd(SEL_BUF, rxbase(0) + k, v);
            if (v[7:0] != rxb[k]) base++;
        end
        chk("R6 stored bytes mismatches", 32'(base), 32'h0);
        chk("R9 irq after frame", {31'h0, irq}, 32'h1);
        sw_wr(SEL_CTRL, CW_IRQ, 32'h1);
        chk("R9 irq after write-1-clear", {31'h0, irq}, 32'h0);

        // R7/R8/R9: overflow into desc1 (last), interrupt masked
        sw_wr(SEL_CTRL, CW_EN, 32'h0);
        send_rx(12, 7'h01);
        wait_rx_free(1, "R7 rx desc1 handed back");
        repeat (2) @(negedge clk);
        sw_rd(SEL_DESC, rxd(1, 1), v);
        chk("R7 count capped at buffer length", v, (32'd8 << 16) | 32'd8);
        sw_rd(SEL_DESC, rxd(1, 0), v);
        chk("R7 R8 overflow+crc status", v, stat_word(7'h01, 1'b1, 1'b1));
        sw_rd(SEL_BUF, rxbase(1) + 8, v);
        chk("R7 byte beyond buffer untouched", v, 32'hA5);
        chk("R9 irq masked", {31'h0, irq}, 32'h0);
        sw_rd(SEL_CTRL, CW_IRQ, v);
        chk("R9 status set while masked", v, 32'h1);
        sw_wr(SEL_CTRL, CW_EN, 32'h1);
        chk("R9 irq after enable", {31'h0, irq}, 32'h1);
        sw_wr(SEL_CTRL, CW_IRQ, 32'h1);

        // R8: random cause patterns across both receive descriptors
        for (int p = 0; p < 2; p++) begin
            arm_rx(0, 64, 1'b0);
            arm_rx(1, 64, 1'b1);
            sw_wr(SEL_CTRL, CW_REQ, 32'h2);
            for (int i = 0; i < 2; i++) begin
                logic [6:0] c;
                c = (p == 0 && i == 0) ? 7'h20 : 7'($urandom);
                l0 = 1 + ($urandom % 64);
                send_rx(l0, c);
                wait_rx_free(i, "R8 rx handed back");
                repeat (2) @(negedge clk);
                sw_rd(SEL_DESC, rxd(i, 0), v);
                chk("R8 status packing", v, stat_word(c, 1'b0, i == 1));
            end
        end

        // R10: software reset mid-receive, then transmit restarts at desc0
        arm_rx(0, 64, 1'b0);
        sw_wr(SEL_CTRL, CW_REQ, 32'h2);
        for (int k = 0; k < 20 && !rx_ready; k++) @(negedge clk);
        sw_wr(SEL_CTRL, CW_RST, 32'h1);
        chk("R10 rx idle after reset", {31'h0, rx_ready}, 32'h0);
        sw_rd(SEL_CTRL, CW_REQ, v);
        chk("R10 request bits cleared", v, 32'h0);
        fill_tx(0, 4, 0);
        arm_tx(0, 4, 1'b0);
        base = txn;
        sw_wr(SEL_CTRL, CW_REQ, 32'h1);
        wait_req_clear(0, "R10 tx after reset");
        repeat (4) @(negedge clk);
        check_stream(base, 4, 4, "R10 ring restarted at desc0");

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule